// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers the event sources of a storage host controller into a single interrupt line. Each source delivers a one-cycle pulse that sets a sticky bit in an 11-bit status register. Software acknowledges a source by writing a zero to its status bit. A written one leaves that bit as it is, so the usual acknowledge value is the inverse of the sources being serviced.

An 11-bit mask register blocks a source when its bit is one. A separate enable register holds a global enable at bit 11. The interrupt output is the OR over all sources of (status AND NOT mask), gated by the global enable, and it is registered.

The output register is a two-state machine. In `IRQ_QUIET` the output is low. The transition from `IRQ_QUIET` to `IRQ_RAISED` is taken on any clock edge where an enabled, unmasked source is pending. The transition from `IRQ_RAISED` back to `IRQ_QUIET` is taken on any edge where none is pending. Source positions are: bit 0 device/command, bit 1 critical error, bit 2 error, bit 3 serial-link error.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is active and just after it, status reads 0, mask reads 0x7FF, the global enable reads 0 and the interrupt output is 0.
- R2: A one-cycle pulse on event bit i sets status bit i on that clock edge. The bit stays set until it is cleared by a write.
- R3: A status write clears every status bit whose written data bit is 0. Bits written with 1 keep their value.
- R4: When an event on bit i and a status write of 0 to bit i happen in the same cycle, the bit ends up set.
- R5: A mask write loads data bits 10:0 into the mask. A mask bit of 1 keeps its source off the interrupt output, and a mask of 0x7FF blocks every source.
- R6: An enable write loads data bit 11 into the global enable. While the enable is 0 the interrupt output is 0.
- R7: The interrupt output equals OR(status AND NOT mask) AND enable as it stood before the previous clock edge. That is, the output lags the registers by one cycle.
- R8: An enable write ignores data bits 10:0. The enable follows bit 11 only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 11 | One-cycle event pulses, one per source |
| stat_wr_i | input | 1 | Status write strobe (write-zero-to-clear) |
| mask_wr_i | input | 1 | Mask write strobe |
| en_wr_i | input | 1 | Enable register write strobe |
| wdata_i | input | 12 | Write data; bits 10:0 for status and mask, bit 11 for the enable |
| status_o | output | 11 | Sticky status register |
| mask_o | output | 11 | Mask register |
| gen_en_o | output | 1 | Global interrupt enable |
| irq_o | output | 1 | Registered interrupt output |

## Verification
A wrong status or mask bit shows up on `status_o` or `mask_o` one edge after the event or write that caused it. It shows up on `irq_o` one edge later still. The bench therefore compares all four outputs against an arithmetic model after every single cycle. This way a lost sticky bit, a clear that takes the wrong polarity, or a clear that beats a simultaneous event is caught within two cycles. A stuck `IRQ_RAISED` or `IRQ_QUIET` state is exposed by the mask and enable sweeps, which toggle the pending condition on each step.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int SRC_W_DEF   = 11;
    localparam int GEN_BIT_DEF = 11;

    localparam int SRC_DEVICE  = 0;
    localparam int SRC_CRIT    = 1;
    localparam int SRC_ERR     = 2;
    localparam int SRC_LINK    = 3;

    typedef enum logic [0:0] {
        IRQ_QUIET  = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/status_bank.sv
module status_bank #(
    parameter int SRC_W = irq_status_pkg::SRC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] event_i,
    input  logic             clr_wr_i,
    input  logic [SRC_W-1:0] clr_data_i,
    output logic [SRC_W-1:0] status_o
);
    for (genvar i = 0; i < SRC_W; i++) begin : g_bit
        logic bit_q;
        logic keep;

        // a written zero drops the bit, a written one keeps it
        assign keep = clr_wr_i ? (bit_q & clr_data_i[i]) : bit_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bit_q <= 1'b0;
            end else begin
                // a new event wins over a clear in the same cycle
                bit_q <= keep | event_i[i];
            end
        end

        assign status_o[i] = bit_q;
    end
endmodule

// File: rtl/mask_bank.sv
module mask_bank #(
    parameter int SRC_W = irq_status_pkg::SRC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_wr_i,
    input  logic [SRC_W-1:0] mask_data_i,
    input  logic             en_wr_i,
    input  logic             en_data_i,
    output logic [SRC_W-1:0] mask_o,
    output logic             gen_en_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_o <= '1;
        end else if (mask_wr_i) begin
            mask_o <= mask_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en_o <= 1'b0;
        end else if (en_wr_i) begin
            gen_en_o <= en_data_i;
        end
    end
endmodule

// File: rtl/irq_fsm.sv
module irq_fsm
    import irq_status_pkg::*;
#(
    parameter int SRC_W = irq_status_pkg::SRC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] status_i,
    input  logic [SRC_W-1:0] mask_i,
    input  logic             gen_en_i,
    output logic             irq_o
);
    irq_state_e state_q;
    irq_state_e state_d;
    logic       pending;

    assign pending = (|(status_i & ~mask_i)) & gen_en_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET:  if (pending)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!pending) state_d = IRQ_QUIET;
            default:    state_d = IRQ_QUIET;
        endcase
    end

    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            IRQ_QUIET:  irq_o = 1'b0;
            IRQ_RAISED: irq_o = 1'b1;
            default:    irq_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int SRC_W   = irq_status_pkg::SRC_W_DEF,
    parameter int GEN_BIT = irq_status_pkg::GEN_BIT_DEF,
    localparam int DATA_W = GEN_BIT + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  event_i,
    input  logic              stat_wr_i,
    input  logic              mask_wr_i,
    input  logic              en_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SRC_W-1:0]  status_o,
    output logic [SRC_W-1:0]  mask_o,
    output logic              gen_en_o,
    output logic              irq_o
);
    logic [SRC_W-1:0] reg_data;
    logic             en_bit;

    assign reg_data = wdata_i[SRC_W-1:0];
    assign en_bit   = wdata_i[GEN_BIT];

    status_bank #(.SRC_W(SRC_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (event_i),
        .clr_wr_i   (stat_wr_i),
        .clr_data_i (reg_data),
        .status_o   (status_o)
    );

    mask_bank #(.SRC_W(SRC_W)) u_mask (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr_i   (mask_wr_i),
        .mask_data_i (reg_data),
        .en_wr_i     (en_wr_i),
        .en_data_i   (en_bit),
        .mask_o      (mask_o),
        .gen_en_o    (gen_en_o)
    );

    irq_fsm #(.SRC_W(SRC_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status_o),
        .mask_i   (mask_o),
        .gen_en_i (gen_en_o),
        .irq_o    (irq_o)
    );
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
    parameter int SRC_W   = 11,
    parameter int GEN_BIT = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic [SRC_W-1:0]   event_i,
    input logic               stat_wr_i,
    input logic               mask_wr_i,
    input logic               en_wr_i,
    input logic [GEN_BIT:0]   wdata_i,
    input logic [SRC_W-1:0]   status_o,
    input logic [SRC_W-1:0]   mask_o,
    input logic               gen_en_o,
    input logic               irq_o
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (status_o == '0 && mask_o == '1 && !gen_en_o && !irq_o)); // R1

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr_i |=> ((status_o & $past(status_o)) == $past(status_o))); // R2

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((status_o & $past(event_i)) == $past(event_i))); // R4

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr_i |=> ((status_o & ~$past(wdata_i[SRC_W-1:0]) & ~$past(event_i)) == '0)); // R3

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_i |=> (mask_o == $past(wdata_i[SRC_W-1:0]))); // R5

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (gen_en_o == $past(wdata_i[GEN_BIT]))); // R8

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_en_o |=> !irq_o); // R6

    AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (irq_o == ((|($past(status_o) & ~$past(mask_o))) && $past(gen_en_o)))); // R7
endmodule

bind irq_status_unit irq_status_unit_chk #(.SRC_W(SRC_W), .GEN_BIT(GEN_BIT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .event_i   (event_i),
    .stat_wr_i (stat_wr_i),
    .mask_wr_i (mask_wr_i),
    .en_wr_i   (en_wr_i),
    .wdata_i   (wdata_i),
    .status_o  (status_o),
    .mask_o    (mask_o),
    .gen_en_o  (gen_en_o),
    .irq_o     (irq_o)
);

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
    localparam int SW = 11;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] event_i = '0;
    logic          stat_wr_i = 1'b0;
    logic          mask_wr_i = 1'b0;
    logic          en_wr_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic [SW-1:0] status_o;
    logic [SW-1:0] mask_o;
    logic          gen_en_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [SW-1:0] m_st;
    logic [SW-1:0] m_mk;
    logic          m_en;

    always #2.5 clk = ~clk;

    irq_status_unit u_irq_status_unit (
        .clk(clk), .rst_n(rst_n), .event_i(event_i), .stat_wr_i(stat_wr_i),
        .mask_wr_i(mask_wr_i), .en_wr_i(en_wr_i), .wdata_i(wdata_i),
        .status_o(status_o), .mask_o(mask_o), .gen_en_o(gen_en_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle of stimulus, starting and ending at a falling edge
    task automatic step(input string tag, input logic [SW-1:0] ev, input logic sw,
                        input logic mw, input logic ew, input logic [DW-1:0] wd);
        logic pend_before;
        event_i = ev; stat_wr_i = sw; mask_wr_i = mw; en_wr_i = ew; wdata_i = wd;
        pend_before = (|(m_st & ~m_mk)) & m_en;
        @(posedge clk);
        #1;
        event_i = '0; stat_wr_i = 1'b0; mask_wr_i = 1'b0; en_wr_i = 1'b0; wdata_i = '0;
        m_st = (sw ? (m_st & wd[SW-1:0]) : m_st) | ev;
        if (mw) m_mk = wd[SW-1:0];
        if (ew) m_en = wd[11];
        @(negedge clk);
        check({tag, " status"}, 32'(status_o), 32'(m_st));
        check({tag, " mask"},   32'(mask_o),   32'(m_mk));
        check({tag, " enable"}, 32'(gen_en_o), 32'(m_en));
        check({tag, " irq"},    32'(irq_o),    32'(pend_before));
    endtask

    initial begin
        m_st = '0; m_mk = '1; m_en = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", 32'(status_o), 32'h0);
        check("R1 mask",   32'(mask_o),   32'h7FF);
        check("R1 enable", 32'(gen_en_o), 32'h0);
        check("R1 irq",    32'(irq_o),    32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release irq", 32'(irq_o), 32'h0);

        // R2 each source sets and holds; all masked so irq stays 0 (R5)
        for (int i = 0; i < SW; i++) begin
            step("R2 set", SW'(1) << i, 1'b0, 1'b0, 1'b0, '0);
            step("R2 hold", '0, 1'b0, 1'b0, 1'b0, '0);
        end
        // R3 clear single bits by writing the inverse
        for (int i = 0; i < SW; i++) begin
            step("R3 clear", '0, 1'b1, 1'b0, 1'b0, DW'(~(SW'(1) << i)));
        end
        // R3 writing ones leaves bits alone
        step("R2 refill", '1, 1'b0, 1'b0, 1'b0, '0);
        step("R3 ones keep", '0, 1'b1, 1'b0, 1'b0, DW'(12'h7FF));
        step("R3 pattern", '0, 1'b1, 1'b0, 1'b0, DW'(12'h555));
        step("R3 pattern2", '0, 1'b1, 1'b0, 1'b0, DW'(12'h0F0));
        // R4 event beats clear in the same cycle
        for (int i = 0; i < SW; i++) begin
            step("R4 collide", SW'(1) << i, 1'b1, 1'b0, 1'b0, '0);
        end
        step("R3 clear all", '0, 1'b1, 1'b0, 1'b0, '0);

        // R8 enable ignores low bits
        step("R8 low bits", '0, 1'b0, 1'b0, 1'b1, DW'(12'h7FF));
        // R6 enable on with bit 11
        step("R6 enable on", '0, 1'b0, 1'b0, 1'b1, DW'(12'h800));

        // R5/R7 per-source mask sweep: one source pending, mask toggles
        for (int i = 0; i < SW; i++) begin
            step("R5 src", SW'(1) << i, 1'b0, 1'b0, 1'b0, '0);
            step("R5 unmask", '0, 1'b0, 1'b1, 1'b0, DW'(~(SW'(1) << i)));
            step("R7 lag", '0, 1'b0, 1'b0, 1'b0, '0);
            step("R5 other", '0, 1'b0, 1'b1, 1'b0, DW'(SW'(1) << i));
            step("R7 lag2", '0, 1'b0, 1'b0, 1'b0, '0);
            step("R5 remask", '0, 1'b0, 1'b1, 1'b0, DW'(12'h7FF));
            step("R3 ack", '0, 1'b1, 1'b0, 1'b0, DW'(~(SW'(1) << i)));
        end

        // R6 global enable gates a pending unmasked source
        step("R5 open", '0, 1'b0, 1'b1, 1'b0, '0);
        step("R2 dev", SW'(1), 1'b0, 1'b0, 1'b0, '0);
        step("R7 raised", '0, 1'b0, 1'b0, 1'b0, '0);
        step("R6 disable", '0, 1'b0, 1'b0, 1'b1, DW'(12'h7FF));
        step("R6 quiet", '0, 1'b0, 1'b0, 1'b0, '0);
        step("R6 reenable", '0, 1'b0, 1'b0, 1'b1, DW'(12'h800));
        step("R7 back", '0, 1'b0, 1'b0, 1'b0, '0);
        step("R3 ack dev", '0, 1'b1, 1'b0, 1'b0, DW'(~SW'(1)));
        step("R7 drop", '0, 1'b0, 1'b0, 1'b0, '0);

        // R1 reset again from a busy state
        step("R2 fill", '1, 1'b0, 1'b0, 1'b0, '0);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 rereset status", 32'(status_o), 32'h0);
        check("R1 rereset mask",   32'(mask_o),   32'h7FF);
        check("R1 rereset enable", 32'(gen_en_o), 32'h0);
        check("R1 rereset irq",    32'(irq_o),    32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule